// File: doc/BRIEF.md
# SPI EEPROM Access Sequencer

This block turns a single request (start address, byte count, direction) into the sequence of SPI transactions a serial EEPROM with a 16-bit address needs. It does not shift bits itself. It drives a byte-transfer engine through a start/done handshake and frames each transaction with a chip-select level. Write data comes in on a valid/ready byte stream, and read data leaves on another valid/ready byte stream.

Requests are cut into chunks of at most `CHUNK` bytes, and the address moves forward by the size of each chunk. A read chunk is one transaction: a command and address header, then one filler byte per data byte. A write chunk takes three steps. First comes a write-enable transaction on its own. Then comes the command, address and data. Last, the status register is polled until the busy flag clears. A gap of `GAP_CYCLES` clocks separates busy polls, and polling stops after `POLL_MAX` tries. When a chunk runs out of polls, a sticky error is raised. A one-cycle `done` pulse ends every request.

Top module: `spi_eeprom_seq`

## Requirements
- R1: A request with length 0 raises `done` in the cycle after it is accepted. It drives no `spi_start` and never raises `spi_sel`.
- R2: The header of every data transaction is an opcode byte, then address bits 15:8, then address bits 7:0. The opcode is 0x03 for a read and 0x02 for a write. A write then sends the stream bytes in order. A read sends one 0x00 filler byte per data byte.
- R3: Each data transaction moves between 1 and `CHUNK` bytes. Chunk k+1 starts at the address of chunk k plus its size. The chunk sizes add up to the request length.
- R4: Every write transaction directly follows a transaction that holds only the byte 0x06. `spi_sel` is low for at least one cycle between the two.
- R5: After a write transaction, the block sends status polls. Each poll is a transaction of 0x05 followed by 0x00. The write is finished when bit 0 of the byte received during the 0x00 is 0.
- R6: After a busy poll that is not the last allowed one, `spi_sel` stays low for at least `GAP_CYCLES` cycles before the next poll. A chunk gets at most `POLL_MAX` polls.
- R7: If all `POLL_MAX` polls of a chunk report busy, `err` goes high and the remaining chunks still run. `err` stays high until the next request is accepted, and accepting a request clears it.
- R8: For reads, the bytes received during the three header bytes are thrown away. The bytes received during the filler bytes appear on `rd_data` in order. `rd_valid` and `rd_data` hold steady until `rd_ready`.
- R9: `done` is a single-cycle pulse after the last chunk finishes. `req_ready` is high only while the block is idle.
- R10: `spi_start` is a single-cycle pulse and occurs only while `spi_sel` is high.
- R11: After reset the block is idle: `req_ready` is 1, and `spi_sel`, `done`, `err`, `rd_valid` and `wr_ready` are 0. `spi_sel` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Start byte address |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken when high with wr_valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken when high with rd_valid |
| rd_data | output | 8 | Read byte |
| spi_sel | output | 1 | Chip select, high = device selected |
| spi_start | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to send, valid with spi_start |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| done | output | 1 | Request finished (pulse) |
| err | output | 1 | A chunk timed out during the last request |

## Verification
The bench uses an engine-and-device model that checks the framing of every transaction. Directed lengths of 0, 5, 20 and 37 cover three cases: no transaction at all, one partial chunk, and splits that carry into the high address byte, which shows whether the address advances by the chunk size. Busy counts below, equal to and above the poll limit separate a normal poll loop from a timeout, and a two-chunk timeout shows that the error is sticky and the later chunk still runs. Header bytes return a junk pattern, so a read that fails to drop them gives wrong data. Random requests with random stalls on both streams then test the handshakes against a shadow memory.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] FILL_BYTE = 8'h00;

    typedef enum logic [4:0] {
        S_IDLE,
        S_LOAD,
        S_WREN,
        S_WREN_W,
        S_HDR,
        S_HDR_W,
        S_WDATA,
        S_RDSEND,
        S_DAT_W,
        S_RDOUT,
        S_POLL_OP,
        S_POLL_OP_W,
        S_POLL_DUM,
        S_POLL_DUM_W,
        S_GAP,
        S_NEXT,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic       start;
        logic [7:0] data;
    } spi_byte_t;

    // Header byte by position: command, high address, low address.
    function automatic logic [7:0] hdr_byte(input logic [1:0] idx,
                                            input logic wr,
                                            input logic [15:0] addr);
        case (idx)
            2'd0:    return wr ? OP_WRITE : OP_READ;
            2'd1:    return addr[15:8];
            default: return addr[7:0];
        endcase
    endfunction

    function automatic logic still_busy(input logic [7:0] status);
        return status[0];
    endfunction

endpackage

// File: rtl/eeseq_chunker.sv
module eeseq_chunker #(
    parameter int LEN_W = 16,
    parameter int CHUNK = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [15:0]      load_addr,
    input  logic [LEN_W-1:0] load_len,
    input  logic             advance,
    output logic [15:0]      cur_addr,
    output logic [CNT_W-1:0] chunk_len,
    output logic             last_chunk
);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK);

    logic [15:0]      addr_q;
    logic [LEN_W-1:0] rem_q;
    logic             fits;

    assign fits       = (rem_q <= CHUNK_L);
    assign chunk_len  = fits ? CNT_W'(rem_q) : CNT_W'(CHUNK);
    assign last_chunk = fits;
    assign cur_addr   = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_len;
        end else if (advance) begin
            addr_q <= addr_q + 16'(chunk_len);
            rem_q  <= rem_q - LEN_W'(chunk_len);
        end
    end

    AST_ADV_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        advance |-> rem_q != '0); // R3
    AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (rst)
        load |-> !advance); // R3

endmodule

// File: rtl/eeseq_poll_timer.sv
module eeseq_poll_timer #(
    parameter int POLL_MAX   = 1000,
    parameter int GAP_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic busy_seen,
    input  logic gap_start,
    output logic final_try,
    output logic gap_done
);
    localparam int TRY_W = $clog2(POLL_MAX + 1);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    logic [TRY_W-1:0] tries_q;
    logic [GAP_W-1:0] gap_q;
    logic             gap_act;

    assign final_try = (tries_q == TRY_W'(POLL_MAX - 1));
    assign gap_done  = gap_act && (gap_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tries_q <= '0;
        end else if (busy_seen) begin
            tries_q <= tries_q + TRY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_act <= 1'b0;
            gap_q   <= '0;
        end else if (gap_start) begin
            gap_act <= 1'b1;
            gap_q   <= GAP_W'(GAP_CYCLES - 1);
        end else if (gap_act) begin
            if (gap_q == '0) begin
                gap_act <= 1'b0;
            end else begin
                gap_q <= gap_q - GAP_W'(1);
            end
        end
    end

    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_seen |-> tries_q < TRY_W'(POLL_MAX)); // R6
    AST_GAP_FRESH: assert property (@(posedge clk) disable iff (rst)
        gap_start |-> !gap_act); // R6

endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
    import eeseq_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int CHUNK      = 16,
    parameter int POLL_MAX   = 1000,
    parameter int GAP_CYCLES = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [15:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             spi_sel,
    output logic             spi_start,
    output logic [7:0]       spi_tx,
    input  logic             spi_done,
    input  logic [7:0]       spi_rx,
    output logic             done,
    output logic             err
);
    localparam int CNT_W = $clog2(CHUNK + 1);

    seq_state_e       state_q;
    logic             wr_q;
    logic [1:0]       idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sel_q;
    spi_byte_t        out_q;
    logic             rdv_q;
    logic [7:0]       rdd_q;
    logic             err_q;

    logic             ck_load, ck_adv, ck_last;
    logic [15:0]      ck_addr;
    logic [CNT_W-1:0] ck_len;
    logic             tm_clear, busy_seen, gap_start, final_try, gap_done;
    logic             last_byte;

    assign req_ready = (state_q == S_IDLE);
    assign wr_ready  = (state_q == S_WDATA);
    assign done      = (state_q == S_DONE);
    assign err       = err_q;
    assign spi_sel   = sel_q;
    assign spi_start = out_q.start;
    assign spi_tx    = out_q.data;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;

    assign ck_load   = req_valid && req_ready;
    assign ck_adv    = (state_q == S_NEXT);
    assign tm_clear  = (state_q == S_LOAD);
    assign busy_seen = (state_q == S_POLL_DUM_W) && spi_done && still_busy(spi_rx);
    assign gap_start = busy_seen && !final_try;
    assign last_byte = (cnt_q == ck_len - CNT_W'(1));

    eeseq_chunker #(
        .LEN_W (LEN_W),
        .CHUNK (CHUNK),
        .CNT_W (CNT_W)
    ) i_chunker (
        .clk        (clk),
        .rst        (rst),
        .load       (ck_load),
        .load_addr  (req_addr),
        .load_len   (req_len),
        .advance    (ck_adv),
        .cur_addr   (ck_addr),
        .chunk_len  (ck_len),
        .last_chunk (ck_last)
    );

    eeseq_poll_timer #(
        .POLL_MAX   (POLL_MAX),
        .GAP_CYCLES (GAP_CYCLES)
    ) i_poll_timer (
        .clk       (clk),
        .rst       (rst),
        .clear     (tm_clear),
        .busy_seen (busy_seen),
        .gap_start (gap_start),
        .final_try (final_try),
        .gap_done  (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            wr_q    <= 1'b0;
            idx_q   <= '0;
            cnt_q   <= '0;
            sel_q   <= 1'b0;
            out_q   <= '0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            out_q.start <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        err_q   <= 1'b0;
                        state_q <= (req_len == '0) ? S_DONE : S_LOAD;
                    end
                end
                S_LOAD: begin
                    cnt_q   <= '0;
                    idx_q   <= '0;
                    state_q <= wr_q ? S_WREN : S_HDR;
                end
                S_WREN: begin
                    sel_q   <= 1'b1;
                    out_q   <= '{start: 1'b1, data: OP_WREN};
                    state_q <= S_WREN_W;
                end
                S_WREN_W: begin
                    if (spi_done) begin
                        sel_q   <= 1'b0;
                        state_q <= S_HDR;
                    end
                end
                S_HDR: begin
                    sel_q   <= 1'b1;
                    out_q   <= '{start: 1'b1, data: hdr_byte(idx_q, wr_q, ck_addr)};
                    state_q <= S_HDR_W;
                end
                S_HDR_W: begin
                    if (spi_done) begin
                        if (idx_q == 2'd2) begin
                            state_q <= wr_q ? S_WDATA : S_RDSEND;
                        end else begin
                            idx_q   <= idx_q + 2'd1;
                            state_q <= S_HDR;
                        end
                    end
                end
                S_WDATA: begin
                    if (wr_valid) begin
                        out_q   <= '{start: 1'b1, data: wr_data};
                        state_q <= S_DAT_W;
                    end
                end
                S_RDSEND: begin
                    out_q   <= '{start: 1'b1, data: FILL_BYTE};
                    state_q <= S_DAT_W;
                end
                S_DAT_W: begin
                    if (spi_done) begin
                        if (last_byte) begin
                            sel_q <= 1'b0;
                        end
                        if (!wr_q) begin
                            rdv_q   <= 1'b1;
                            rdd_q   <= spi_rx;
                            state_q <= S_RDOUT;
                        end else begin
                            cnt_q   <= cnt_q + CNT_W'(1);
                            state_q <= last_byte ? S_POLL_OP : S_WDATA;
                        end
                    end
                end
                S_RDOUT: begin
                    if (rd_ready) begin
                        rdv_q   <= 1'b0;
                        cnt_q   <= cnt_q + CNT_W'(1);
                        state_q <= last_byte ? S_NEXT : S_RDSEND;
                    end
                end
                S_POLL_OP: begin
                    sel_q   <= 1'b1;
                    out_q   <= '{start: 1'b1, data: OP_RDSR};
                    state_q <= S_POLL_OP_W;
                end
                S_POLL_OP_W: begin
                    if (spi_done) begin
                        state_q <= S_POLL_DUM;
                    end
                end
                S_POLL_DUM: begin
                    out_q   <= '{start: 1'b1, data: FILL_BYTE};
                    state_q <= S_POLL_DUM_W;
                end
                S_POLL_DUM_W: begin
                    if (spi_done) begin
                        sel_q <= 1'b0;
                        if (!still_busy(spi_rx)) begin
                            state_q <= S_NEXT;
                        end else if (final_try) begin
                            err_q   <= 1'b1;
                            state_q <= S_NEXT;
                        end else begin
                            state_q <= S_GAP;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_done) begin
                        state_q <= S_POLL_OP;
                    end
                end
                S_NEXT: begin
                    state_q <= ck_last ? S_DONE : S_LOAD;
                end
                S_DONE: begin
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    AST_START_UNDER_SEL: assert property (@(posedge clk) disable iff (rst)
        spi_start |-> spi_sel); // R10
    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        spi_start |=> !spi_start); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err && !(req_valid && req_ready)) |=> err); // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !err); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R8
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !spi_sel); // R11

endmodule

// File: tb/test_spi_eeprom_seq.sv
module test_spi_eeprom_seq;
    localparam int CH  = 16;
    localparam int PM  = 4;
    localparam int GAP = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_len = '0;
    logic        wr_valid = 1'b0, rd_ready = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = '0;
    logic        req_ready, wr_ready, rd_valid, spi_sel, spi_start, done, err;
    logic [7:0]  rd_data, spi_tx;

    always #10 clk = ~clk;

    spi_eeprom_seq #(.LEN_W(16), .CHUNK(CH), .POLL_MAX(PM), .GAP_CYCLES(GAP)) i_spi_eeprom_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .spi_sel(spi_sel), .spi_start(spi_start), .spi_tx(spi_tx),
        .spi_done(spi_done), .spi_rx(spi_rx), .done(done), .err(err));

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- engine and device model ----------------
    logic [7:0]  ee_mem [256];
    logic [7:0]  exp_mem [256];
    int          cyc = 0;
    bit          sel_seen = 0, pend = 0, wel = 0, last_busy = 0, prev_busy = 0;
    int          lat = 0, bidx = 0, ndata = 0, busy_left = 0, busy_cfg = 0;
    logic [7:0]  op = 0, prev_op = 0, rxb = 0;
    int          prev_bytes = 0, tr_count = 0, prot_err = 0;
    int          polls_chunk = 0, max_polls = 0, gap_min = 1000000;
    int          rise_cyc = 0, fall_cyc = 0;
    logic [15:0] taddr = 0, tstart = 0;
    logic [15:0] ck_addr [8];
    int          ck_len [8];
    int          ck_n = 0;

    always @(posedge clk) cyc++;

    task dev_byte(input logic [7:0] tx, output logic [7:0] rx);
        rx = 8'hA5;
        if (bidx == 0) begin
            op = tx;
            if (tx == 8'h06) wel = 1;
        end else if (op == 8'h02 || op == 8'h03) begin
            if (bidx == 1) taddr[15:8] = tx;
            else if (bidx == 2) begin taddr[7:0] = tx; tstart = taddr; end
            else begin
                if (op == 8'h02) ee_mem[taddr[7:0]] = tx;
                else rx = ee_mem[taddr[7:0]];
                taddr++;
                ndata++;
            end
        end else if (op == 8'h05 && bidx == 1) begin
            last_busy = (busy_left > 0);
            rx = {7'b0, last_busy};
            if (busy_left > 0) busy_left--;
        end
        bidx++;
    endtask

    task end_tr();
        tr_count++;
        if (op == 8'h06 && bidx != 1) prot_err++;
        if (op == 8'h02 || op == 8'h03) begin
            if (ndata == 0 || ndata > CH) prot_err++;
            if (ck_n < 8) begin ck_addr[ck_n] = tstart; ck_len[ck_n] = ndata; end
            ck_n++;
        end
        if (op == 8'h02) begin
            if (!(prev_op == 8'h06 && prev_bytes == 1 && wel)) prot_err++;
            wel = 0;
            busy_left = busy_cfg;
            polls_chunk = 0;
        end
        if (op == 8'h05) begin
            if (bidx != 2) prot_err++;
            polls_chunk++;
            if (polls_chunk > max_polls) max_polls = polls_chunk;
            if (prev_op == 8'h05 && prev_busy && (rise_cyc - fall_cyc) < gap_min)
                gap_min = rise_cyc - fall_cyc;
            prev_busy = last_busy;
            fall_cyc = cyc;
        end
        prev_op = op;
        prev_bytes = bidx;
    endtask

    always @(negedge clk) begin
        if (spi_sel && !sel_seen) begin bidx = 0; ndata = 0; rise_cyc = cyc; end
        if (!spi_sel && sel_seen) end_tr();
        sel_seen = spi_sel;
        spi_done = 1'b0;
        if (pend) begin
            if (lat == 0) begin spi_done = 1'b1; spi_rx = rxb; pend = 0; end
            else lat--;
        end
        if (spi_start) begin pend = 1; lat = 1; dev_byte(spi_tx, rxb); end
    end

    // ---------------- stream models ----------------
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];
    int widx = 0, wlen = 0, ridx = 0;
    bit feeding = 0, hs_pend = 0;

    always @(negedge clk) begin
        if (hs_pend) widx++;
        wr_data  = wbuf[widx % 64];
        wr_valid = feeding && (widx < wlen) && ($urandom % 4 != 0);
        hs_pend  = wr_valid && wr_ready;
        rd_ready = ($urandom % 3 != 0);
        if (rd_valid && rd_ready) begin
            if (ridx < 64) rbuf[ridx] = rd_data;
            ridx++;
        end
    end

    // ---------------- request driver ----------------
    task automatic run_req(input bit w, input logic [15:0] a, input int len,
                           input int b, input string tag);
        int n = 0;
        int tr0;
        bit ok;
        int rem;
        int l;
        int i;
        int exp_polls;
        logic [15:0] ea;
        busy_cfg = b; ck_n = 0; prot_err = 0; max_polls = 0; gap_min = 1000000;
        prev_busy = 0; ridx = 0; widx = 0; hs_pend = 0; wlen = w ? len : 0;
        for (int k = 0; k < 64; k++) wbuf[k] = 8'($urandom);
        feeding = w;
        tr0 = tr_count;
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_len = 16'(len);
        @(negedge clk);
        req_valid = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        feeding = 0;
        chk(done, "R9", {tag, " done seen"}, done, 1);
        if (len == 0) begin
            chk(n == 0, "R1", {tag, " zero-length done latency"}, n, 0);
            chk(tr_count == tr0, "R1", {tag, " no transactions"}, tr_count - tr0, 0);
            return;
        end
        // chunk list
        ok = 1; rem = len; ea = a; i = 0;
        while (rem > 0) begin
            l = (rem > CH) ? CH : rem;
            if (i >= 8 || i >= ck_n || ck_addr[i] != ea || ck_len[i] != l) ok = 0;
            ea = ea + 16'(l); rem -= l; i++;
        end
        if (i != ck_n) ok = 0;
        chk(ok, "R3", {tag, " chunk addresses and sizes"}, ck_n, i);
        chk(prot_err == 0, "R4", {tag, " transaction framing"}, prot_err, 0);
        if (w) begin
            for (int k = 0; k < len; k++) exp_mem[8'(a + 16'(k))] = wbuf[k];
            ok = 1;
            for (int k = 0; k < len; k++)
                if (ee_mem[8'(a + 16'(k))] != exp_mem[8'(a + 16'(k))]) ok = 0;
            chk(ok, "R2", {tag, " written bytes at header address"}, ok, 1);
            exp_polls = (b >= PM) ? PM : b + 1;
            chk(max_polls == exp_polls, "R5", {tag, " polls per chunk"}, max_polls, exp_polls);
            if (b > 0)
                chk(gap_min >= GAP, "R6", {tag, " gap between polls"}, gap_min, GAP);
            chk(err == (b >= PM), "R7", {tag, " err after write"}, err, b >= PM);
        end else begin
            ok = (ridx == len);
            for (int k = 0; k < len && k < 64; k++)
                if (rbuf[k] != exp_mem[8'(a + 16'(k))]) ok = 0;
            chk(ok, "R8", {tag, " read data stream"}, ridx, len);
            chk(err == 0, "R7", {tag, " no err on read"}, err, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 256; k++) begin ee_mem[k] = 8'(k * 7 + 3); exp_mem[k] = 8'(k * 7 + 3); end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R11", "reset req_ready", req_ready, 1);
        chk(!spi_sel && !done && !err, "R11", "reset sel/done/err", {spi_sel, done, err}, 0);
        chk(!rd_valid && !wr_ready, "R11", "reset stream outputs", {rd_valid, wr_ready}, 0);

        run_req(1, 16'h0000, 0, 0, "zero write");
        run_req(1, 16'h0130, 5, 1, "short write");
        run_req(0, 16'h0130, 5, 0, "short read");
        run_req(1, 16'h00F8, 20, 0, "split write");
        run_req(0, 16'h00F0, 37, 0, "split read");
        run_req(1, 16'h0240, 3, PM - 1, "last-try write");
        run_req(1, 16'h0350, 18, PM + 2, "timeout write");
        repeat (5) @(negedge clk);
        chk(err == 1, "R7", "err held while idle", err, 1);
        chk(!spi_sel, "R11", "sel low when idle", spi_sel, 0);
        run_req(0, 16'h0000, 0, 0, "zero read");
        chk(err == 0, "R7", "err cleared by next request", err, 0);
        run_req(0, 16'h0350, 18, 0, "readback after timeout");

        for (int it = 0; it < 24; it++) begin
            run_req(1'($urandom % 2), 16'($urandom), int'($urandom % 41),
                    ($urandom % 8 == 0) ? PM + 1 : int'($urandom % 3), "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule